// File: doc/BRIEF.md
# Accumulator ALU with Decimal Adjust

This block is the arithmetic core of a small 8-bit processor datapath. It holds one accumulator and a five-flag condition register. Each accepted request runs one operation: add a memory operand, add it with the carry flag, decrement the accumulator, shift the accumulator left or right arithmetically, or correct the accumulator into packed BCD after a decimal addition. The result and the flags are written on the clock edge that accepts the request.

Requests arrive on a valid/ready pair. The block finishes every operation in a single cycle, so it never applies back-pressure: `op_ready` is low only while reset is asserted and for the first edge after it, and is high from then on. A request counts when `op_valid` and `op_ready` are both high at a rising clock edge. The operand and operation select need to be stable only at that edge. A source that sees `op_ready` low holds its request until the block raises it.

The decimal adjust operation uses the half-carry and carry flags left by the addition just before it. It is meaningful only directly after an add or an add with carry of two packed BCD bytes.

Top module: `acc_alu`

## Requirements
- R1: While `rst_n` is low, the accumulator is 0x00, every flag is 0 and `op_ready` is low. From the second rising edge after reset release, `op_ready` is high. Flags appear on `flags_out` as {H,N,Z,V,C}, with H at bit 4 and C at bit 0.
- R2: Operation code 0 (add) stores acc+operand. Code 1 (add with carry) stores acc+operand+C. In both, C is the carry out of bit 7 and H is the carry out of bit 3 of the full sum.
- R3: Every operation with code 0 to 5 sets N to bit 7 of the new accumulator and sets Z exactly when the new accumulator is 0x00.
- R4: Codes 0 and 1 set V exactly when the two addends have the same sign and the result's sign differs from theirs.
- R5: Code 2 (decrement) stores acc-1. V is set only when the old accumulator was 0x80. C and H keep their values.
- R6: Code 3 (shift left) moves bit 7 into C and a zero into bit 0. Code 4 (shift right) moves bit 0 into C and keeps bit 7. After either shift, V equals N xor C. H keeps its value.
- R7: Code 5 (decimal adjust) adds 0x06 when H is set or the low nibble is above 9. It adds 0x60 when C is set, when the high nibble is above 9, or when the high nibble is 9 and the low nibble is above 9. It then sets C if C was set or if 0x60 was added, so it never clears C. H keeps its value and V is unspecified.
- R8: For every pair of two-digit BCD bytes and either carry-in, add-with-carry followed by decimal adjust leaves the BCD sum modulo 100 in the accumulator, with C equal to the decimal carry.
- R9: With `op_valid` low, or with reserved codes 6 and 7, the accumulator and the flags do not change.
- R10: The result of an accepted request is visible on `acc_out` and `flags_out` after the accepting edge and not before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Request present |
| op_ready | output | 1 | Block can accept a request |
| op_sel | input | 3 | Operation code (0 add, 1 add with carry, 2 decrement, 3 shift left, 4 shift right, 5 decimal adjust, 6 and 7 reserved) |
| operand | input | 8 | Memory operand for the two additions |
| acc_out | output | 8 | Accumulator |
| flags_out | output | 5 | Flags {H,N,Z,V,C} |

## Verification
The bench goes after the decimal adjust corner cases. With H set and a low nibble of 9 or less, a design that ignores H leaves a digit six too low. With a high nibble of 9 and a low nibble above 9, a design that misses the carry from the low correction leaves a non-BCD upper digit. When C is set from the addition and no upper correction would otherwise be needed, a design that recomputes C clears it. It also checks that decrement raises V only when it steps from 0x80 to 0x7F and keeps C, that both shifts derive V from the shifted result, and that add with carry counts the carry into the half-carry. An exhaustive sweep of every BCD operand pair, with and without carry-in, catches any remaining digit or carry error.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

  localparam int NIB_W = 4;

  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_ADC  = 3'd1,
    OP_DEC  = 3'd2,
    OP_ASL  = 3'd3,
    OP_ASR  = 3'd4,
    OP_DAA  = 3'd5,
    OP_RSV6 = 3'd6,
    OP_RSV7 = 3'd7
  } acc_op_e;

  typedef struct packed {
    logic h;
    logic n;
    logic z;
    logic v;
    logic c;
  } ccr_t;

endpackage

// File: rtl/acc_adder.sv
module acc_adder
  import acc_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         c_out,
  output logic         h_out,
  output logic         v_out
);

  logic [W:0]     full;
  logic [NIB_W:0] low;

  // Low-nibble sum gives the half carry; full sum gives the carry.
  assign low   = {1'b0, a[NIB_W-1:0]} + {1'b0, b[NIB_W-1:0]} + {{NIB_W{1'b0}}, cin};
  assign full  = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
  assign sum   = full[W-1:0];
  assign c_out = full[W];
  assign h_out = low[NIB_W];
  // Signed overflow: operands agree in sign, result disagrees.
  assign v_out = (a[W-1] == b[W-1]) && (full[W-1] != a[W-1]);

endmodule

// File: rtl/acc_shifter.sv
module acc_shifter #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic         to_right,
  output logic [W-1:0] res,
  output logic         c_out
);

  always_comb begin
    if (to_right) begin
      res   = {a[W-1], a[W-1:1]};
      c_out = a[0];
    end else begin
      res   = {a[W-2:0], 1'b0};
      c_out = a[W-1];
    end
  end

endmodule

// File: rtl/acc_decadj.sv
module acc_decadj
  import acc_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic         h_in,
  input  logic         c_in,
  output logic [W-1:0] res,
  output logic         c_out
);

  localparam logic [NIB_W-1:0] DIGIT_MAX = NIB_W'(9);
  localparam logic [NIB_W-1:0] FIX       = NIB_W'(6);

  logic [NIB_W-1:0] lo_dig, hi_dig;
  logic             lo_fix, hi_fix;
  logic [W-1:0]     corr;

  assign lo_dig = a[NIB_W-1:0];
  assign hi_dig = a[W-1 -: NIB_W];

  assign lo_fix = h_in || (lo_dig > DIGIT_MAX);
  assign hi_fix = c_in || (hi_dig > DIGIT_MAX) ||
                  ((hi_dig == DIGIT_MAX) && (lo_dig > DIGIT_MAX));

  assign corr  = {(hi_fix ? FIX : '0), (lo_fix ? FIX : '0)};
  assign res   = a + corr;
  // Carry is sticky: only ever raised here.
  assign c_out = c_in | hi_fix;

endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  output logic              op_ready,
  input  logic [2:0]        op_sel,
  input  logic [DATA_W-1:0] operand,
  output logic [DATA_W-1:0] acc_out,
  output logic [4:0]        flags_out
);

  localparam logic [DATA_W-1:0] MIN_NEG = {1'b1, {(DATA_W-1){1'b0}}};
  localparam logic [DATA_W-1:0] ONE     = DATA_W'(1);

  logic [DATA_W-1:0] acc_q, acc_d;
  ccr_t              ccr_q, ccr_d;
  logic              ready_q;
  logic              take;
  acc_op_e           op_e;

  assign op_e = acc_op_e'(op_sel);
  assign take = op_valid && ready_q;

  // Adder path
  logic [DATA_W-1:0] add_sum;
  logic              add_c, add_h, add_v;

  acc_adder #(.W(DATA_W)) u_adder (
    .a     (acc_q),
    .b     (operand),
    .cin   ((op_e == OP_ADC) && ccr_q.c),
    .sum   (add_sum),
    .c_out (add_c),
    .h_out (add_h),
    .v_out (add_v)
  );

  // Shift path
  logic [DATA_W-1:0] sh_res;
  logic              sh_c;

  acc_shifter #(.W(DATA_W)) u_shift (
    .a        (acc_q),
    .to_right (op_e == OP_ASR),
    .res      (sh_res),
    .c_out    (sh_c)
  );

  // Decimal adjust path
  logic [DATA_W-1:0] daa_res;
  logic              daa_c;

  acc_decadj #(.W(DATA_W)) u_decadj (
    .a     (acc_q),
    .h_in  (ccr_q.h),
    .c_in  (ccr_q.c),
    .res   (daa_res),
    .c_out (daa_c)
  );

  // Decrement path
  logic [DATA_W-1:0] dec_res;
  assign dec_res = acc_q - ONE;

  always_comb begin
    acc_d = acc_q;
    ccr_d = ccr_q;
    if (take) begin
      unique case (op_e)
        OP_ADD, OP_ADC: begin
          acc_d   = add_sum;
          ccr_d.h = add_h;
          ccr_d.c = add_c;
          ccr_d.v = add_v;
        end
        OP_DEC: begin
          acc_d   = dec_res;
          ccr_d.v = (acc_q == MIN_NEG);
        end
        OP_ASL, OP_ASR: begin
          acc_d   = sh_res;
          ccr_d.c = sh_c;
          ccr_d.v = sh_res[DATA_W-1] ^ sh_c;
        end
        OP_DAA: begin
          acc_d   = daa_res;
          ccr_d.c = daa_c;
        end
        default: ;
      endcase
      if (op_e != OP_RSV6 && op_e != OP_RSV7) begin
        ccr_d.n = acc_d[DATA_W-1];
        ccr_d.z = (acc_d == '0);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q   <= '0;
      ccr_q   <= '0;
      ready_q <= 1'b0;
    end else begin
      acc_q   <= acc_d;
      ccr_q   <= ccr_d;
      ready_q <= 1'b1;
    end
  end

  assign acc_out   = acc_q;
  assign flags_out = ccr_q;
  assign op_ready  = ready_q;

  // Assertions guarding the update rules
  assert_hold_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!take || op_e == OP_RSV6 || op_e == OP_RSV7) |=> $stable(acc_out) && $stable(flags_out));

  assert_add_sum_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (take && op_e == OP_ADD) |=> acc_out == DATA_W'($past(acc_out) + $past(operand)));

  assert_zero_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (take && op_e != OP_RSV6 && op_e != OP_RSV7) |=>
      (flags_out[2] == (acc_out == '0)) && (flags_out[3] == acc_out[DATA_W-1]));

  assert_dec_v_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (take && op_e == OP_DEC) |=> flags_out[1] == ($past(acc_out) == MIN_NEG));

  assert_dec_keeps_c_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (take && op_e == OP_DEC) |=> (flags_out[0] == $past(flags_out[0])) &&
                                 (flags_out[4] == $past(flags_out[4])));

  assert_shift_v_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (take && (op_e == OP_ASL || op_e == OP_ASR)) |=> flags_out[1] == (flags_out[3] ^ flags_out[0]));

  assert_daa_c_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (take && op_e == OP_DAA && flags_out[0]) |=> flags_out[0]);

endmodule

// File: tb/acc_alu_tb.sv
module acc_alu_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC       = 28;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       op_valid = 1'b0;
  logic       op_ready;
  logic [2:0] op_sel = 3'd0;
  logic [7:0] operand = 8'h00;
  logic [7:0] acc_out;
  logic [4:0] flags_out;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  acc_alu u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_valid  (op_valid),
    .op_ready  (op_ready),
    .op_sel    (op_sel),
    .operand   (operand),
    .acc_out   (acc_out),
    .flags_out (flags_out)
  );

  // {op, operand, expected acc, expected {H,N,Z,V,C}}; V ignored after code 5
  localparam logic [23:0] VEC [0:NVEC-1] = '{
    {3'd0, 8'h08, 8'h08, 5'b00000},
    {3'd0, 8'h06, 8'h0E, 5'b00000},
    {3'd5, 8'h00, 8'h14, 5'b00000},
    {3'd0, 8'h33, 8'h47, 5'b00000},
    {3'd0, 8'h78, 8'hBF, 5'b01010},
    {3'd5, 8'h00, 8'h25, 5'b00001},
    {3'd1, 8'h00, 8'h26, 5'b00000},
    {3'd0, 8'hDA, 8'h00, 5'b10101},
    {3'd2, 8'h00, 8'hFF, 5'b11001},
    {3'd3, 8'h00, 8'hFE, 5'b11001},
    {3'd0, 8'h82, 8'h80, 5'b11001},
    {3'd2, 8'h00, 8'h7F, 5'b10011},
    {3'd3, 8'h00, 8'hFE, 5'b11010},
    {3'd4, 8'h00, 8'hFF, 5'b11010},
    {3'd4, 8'h00, 8'hFF, 5'b11001},
    {3'd1, 8'h7F, 8'h7F, 5'b10001},
    {3'd1, 8'h00, 8'h80, 5'b11010},
    {3'd4, 8'h00, 8'hC0, 5'b11010},
    {3'd3, 8'h00, 8'h80, 5'b11001},
    {3'd3, 8'h00, 8'h00, 5'b10111},
    {3'd6, 8'h55, 8'h00, 5'b10111},
    {3'd0, 8'h01, 8'h01, 5'b00000},
    {3'd2, 8'h00, 8'h00, 5'b00100},
    {3'd0, 8'h99, 8'h99, 5'b01000},
    {3'd0, 8'h99, 8'h32, 5'b10011},
    {3'd5, 8'h00, 8'h98, 5'b11001},
    {3'd0, 8'h02, 8'h9A, 5'b01000},
    {3'd5, 8'h00, 8'h00, 5'b00101}
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // Drive at a falling edge; returns at the next falling edge, after the update.
  task automatic issue(input logic [2:0] op, input logic [7:0] m);
    op_sel   = op;
    operand  = m;
    op_valid = 1'b1;
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  function automatic logic [7:0] to_bcd(input int v);
    return {4'(v / 10), 4'(v % 10)};
  endfunction

  function automatic string op_tag(input logic [2:0] op);
    case (op)
      3'd0, 3'd1: return "R2,R3,R4 add";
      3'd2:       return "R5,R3 dec";
      3'd3, 3'd4: return "R6,R3 shift";
      3'd5:       return "R7,R3 decimal adjust";
      default:    return "R9 reserved";
    endcase
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R10 watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check(acc_out == 8'h00, "R1 reset acc", acc_out, 0);
    check(flags_out == 5'b0, "R1 reset flags", flags_out, 0);
    check(op_ready == 1'b0, "R1 ready in reset", op_ready, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(op_ready == 1'b1, "R1 ready after reset", op_ready, 1);

    // Vector table
    for (int i = 0; i < NVEC; i++) begin
      logic [2:0] vop;
      logic [7:0] vm, va;
      logic [4:0] vf, mask;
      {vop, vm, va, vf} = VEC[i];
      mask = (vop == 3'd5) ? 5'b11101 : 5'b11111;
      issue(vop, vm);
      check(acc_out == va, {op_tag(vop), " acc"}, acc_out, va);
      check((flags_out & mask) == (vf & mask), {op_tag(vop), " flags"},
            flags_out & mask, vf & mask);
    end

    // R9: valid low leaves state alone for several cycles
    begin
      logic [7:0] a0;
      logic [4:0] f0;
      issue(3'd0, 8'h3C);
      a0 = acc_out;
      f0 = flags_out;
      op_sel  = 3'd0;
      operand = 8'h11;
      repeat (3) @(negedge clk);
      check(acc_out == a0, "R9 idle acc", acc_out, a0);
      check(flags_out == f0, "R9 idle flags", flags_out, f0);
      issue(3'd7, 8'hAA);
      check(acc_out == a0, "R9 code 7 acc", acc_out, a0);
      check(flags_out == f0, "R9 code 7 flags", flags_out, f0);
    end

    // R10: no change before the accepting edge, change after it
    begin
      logic [7:0] a0;
      a0 = acc_out;
      op_sel   = 3'd0;
      operand  = 8'h01;
      op_valid = 1'b1;
      #(CLK_PERIOD/2 - 1);
      check(acc_out == a0, "R10 before edge", acc_out, a0);
      @(negedge clk);
      op_valid = 1'b0;
      check(acc_out == 8'(a0 + 8'h01), "R10 after edge", acc_out, 8'(a0 + 8'h01));
    end

    // R8: every BCD pair, both carry-ins
    for (int cin = 0; cin < 2; cin++) begin
      for (int x = 0; x < 100; x++) begin
        for (int y = 0; y < 100; y++) begin
          int s;
          if (cin == 0) begin
            issue(3'd0, 8'(8'h00 - acc_out));
            issue(3'd0, to_bcd(x));
          end else begin
            issue(3'd0, 8'(8'hFF - acc_out));
            issue(3'd0, 8'(to_bcd(x) + 8'h01));
          end
          issue(3'd1, to_bcd(y));
          issue(3'd5, 8'h00);
          s = x + y + cin;
          check(acc_out == to_bcd(s % 100) && flags_out[0] == (s >= 100),
                "R8 bcd sum {acc,C}", {acc_out, flags_out[0]},
                {to_bcd(s % 100), 1'(s >= 100)});
        end
      end
    end

    // R1: reset in mid-run clears at once
    issue(3'd0, 8'h80);
    rst_n = 1'b0;
    #1;
    check(acc_out == 8'h00, "R1 mid-run reset acc", acc_out, 0);
    check(flags_out == 5'b0, "R1 mid-run reset flags", flags_out, 0);
    check(op_ready == 1'b0, "R1 mid-run reset ready", op_ready, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule